// File: doc/BRIEF.md
# Dual-Length PRBS Generator and Checker

This block is a per-channel pseudo-random test pattern engine for a serial line channel. Its transmit half, clocked by the line transmit clock, substitutes an unframed maximal-length pseudo-random bit sequence for the system payload. Its receive half, clocked by the receive clock, aligns itself to the incoming bit stream, flags every bit that departs from the expected pattern on a one-bit error output, and totals those errors in a saturating counter that the host reads and clears.

A single enable input starts both halves together. A line-mode input picks the pattern. Mode 0 uses the 15-stage sequence that suits DS3 and STS-1 rates. Mode 1 uses the 23-stage sequence that suits E3. Data moves one bit per clock on a single rail. Dropping the enable, or changing the line mode, returns both halves to their starting state on the next clock edge.

The checker takes its first reference from the received bits. It waits for a run of clean bits before it trusts that reference. Once it is locked, it runs its reference freely, so a single corrupted bit is counted once. If errors become dense, it gives up and searches again.

Top module: `prbs_engine`

## Requirements
- R1: With the enable low, each transmit clock edge copies txDataIn to txDataOut, so the output shows the input one edge later. The error output and the lock output stay low. After reset, every output is 0.
- R2: With the enable high and lineMode 0, the transmit bits b[n] obey b[n] = b[n-15] XOR b[n-14] (polynomial x^15+x^14+1). The value of txDataIn has no effect on them.
- R3: With the enable high and lineMode 1, the transmit bits obey b[n] = b[n-23] XOR b[n-18] (polynomial x^23+x^18+1). They do not follow the 15-stage rule.
- R4: The generator register never holds all zeros. The generator restarts from all ones, so the transmitted pattern always contains ones.
- R5: The checker loads its reference from the first L received bits, where L is 15 in mode 0 and 23 in mode 1. It then needs 32 further bits in a row that match its prediction. lockOut goes high at the edge that takes bit L+32.
- R6: While locked, a bit that disagrees with the prediction drives errOut high for exactly the one cycle after the edge that took that bit, and adds one to errCount. An isolated error does not break lock.
- R7: While locked, errors are counted in 32-bit windows that start at the edge where lock was gained. Seven errors in one window keep lock. The eighth error in a window is counted, and lock is lost at that edge. The checker then reseeds and locks again after L+32 further clean bits.
- R8: Whenever the checker is not locked, errOut stays low and errCount does not change. A mismatch while it is confirming lock sends it back to reseeding.
- R9: errCount stops at its all-ones value, which is 0xFFFF at the default width, and further errors leave it there.
- R10: errCountClr high at a receive clock edge sets errCount to 0 at that edge. This clear overrides an error that arrives at the same edge.
- R11: Changing lineMode while enabled, or dropping the enable, makes lockOut low after the next edge. Both halves restart from the seed state.
- R12: A received stream of all zeros never produces lock, because an all-zero reference is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset for both halves |
| prbsEn | input | 1 | Enables the generator and the checker together |
| lineMode | input | 1 | Pattern select: 0 = 15-stage, 1 = 23-stage |
| txClk | input | 1 | Transmit line clock |
| txDataIn | input | 1 | System transmit bit |
| txDataOut | output | 1 | Transmit bit toward the line (the pattern when enabled) |
| rxClk | input | 1 | Receive line clock |
| rxDataIn | input | 1 | Received line bit |
| errCountClr | input | 1 | Clears the error counter (receive clock domain) |
| errOut | output | 1 | One-cycle pulse for each bit error seen while locked |
| lockOut | output | 1 | High while the checker is locked |
| errCount | output | CNT_W | Saturating count of errors seen while locked |

## Verification
The bench places errors at chosen offsets inside the 32-bit windows that follow lock. It uses seven errors to show that lock survives and an eighth to show that lock is lost on exactly that bit. A design with an off-by-one in its window or threshold would drop lock one bit early or late. A mismatch placed during lock confirmation must restart the search and must not be counted. A design that self-synchronises its reference would count one flipped bit several times. A narrow second instance shows that the counter saturates, and that a clear arriving with an error still leaves zero. An all-zero input stream must never lock, and a mode change must unlock at the next edge. The transmit stream is checked against both recurrences, so a design with swapped taps fails.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  localparam int SHORT_LEN = 15;
  localparam int SHORT_TAP = 14;
  localparam int LONG_LEN  = 23;
  localparam int LONG_TAP  = 18;
  localparam int REG_W     = LONG_LEN;

  typedef enum logic [1:0] {
    CHK_HUNT   = 2'd0,
    CHK_VERIFY = 2'd1,
    CHK_LOCKED = 2'd2
  } chkState_e;

  // strobes issued by the receive control to the receive datapath
  typedef struct packed {
    logic seedShift;  // shift the received bit into the reference
    logic runShift;   // shift the predicted bit into the reference
    logic errHit;     // count this bit as an error
  } chkStrobe_t;

  function automatic logic prbsFeedback(input logic [REG_W-1:0] r, input logic longMode);
    logic fb;
    if (longMode) fb = r[LONG_LEN-1] ^ r[LONG_TAP-1];
    else          fb = r[SHORT_LEN-1] ^ r[SHORT_TAP-1];
    return fb;
  endfunction

  function automatic logic prbsAllZero(input logic [REG_W-1:0] r, input logic longMode);
    logic z;
    if (longMode) z = (r == '0);
    else          z = (r[SHORT_LEN-1:0] == '0);
    return z;
  endfunction

endpackage

// File: rtl/prbs_tx_gen.sv
module prbs_tx_gen
  import prbs_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic en,
  input  logic longMode,
  input  logic dataIn,
  output logic dataOut
);

  localparam logic [REG_W-1:0] SEED = '1;

  logic [REG_W-1:0] genReg;
  logic             modeQ;
  logic             restart;
  logic             fbBit;

  assign restart = !en || (longMode != modeQ);
  assign fbBit   = prbsFeedback(genReg, longMode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genReg  <= SEED;
      modeQ   <= 1'b0;
      dataOut <= 1'b0;
    end else begin
      modeQ   <= longMode;
      dataOut <= en ? fbBit : dataIn;
      if (restart) genReg <= SEED;
      else         genReg <= {genReg[REG_W-2:0], fbBit};
    end
  end

  // R4
  gen_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    genReg != '0);

  // R1
  tx_passthrough_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (dataOut == $past(dataIn)));

  // R11
  gen_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && (longMode != modeQ)) |=> (genReg == SEED));

endmodule

// File: rtl/prbs_rx_ctrl.sv
module prbs_rx_ctrl
  import prbs_pkg::*;
#(
  parameter int LOCK_RUN  = 32,
  parameter int WIN_LEN   = 32,
  parameter int LOSS_ERRS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       en,
  input  logic       longMode,
  input  logic       mismatch,
  input  logic       refZero,
  output chkStrobe_t strobe,
  output logic       locked
);

  localparam int SEED_W = $clog2(LONG_LEN);
  localparam int RUN_W  = (LOCK_RUN  > 1) ? $clog2(LOCK_RUN)  : 1;
  localparam int WIN_W  = (WIN_LEN   > 1) ? $clog2(WIN_LEN)   : 1;
  localparam int ERR_W  = (LOSS_ERRS > 1) ? $clog2(LOSS_ERRS) : 1;
  localparam logic [SEED_W-1:0] SEED_LAST_S = SEED_W'(SHORT_LEN - 1);
  localparam logic [SEED_W-1:0] SEED_LAST_L = SEED_W'(LONG_LEN - 1);
  localparam logic [RUN_W-1:0]  RUN_LAST    = RUN_W'(LOCK_RUN - 1);
  localparam logic [WIN_W-1:0]  WIN_LAST    = WIN_W'(WIN_LEN - 1);
  localparam logic [ERR_W-1:0]  ERR_LAST    = ERR_W'(LOSS_ERRS - 1);

  chkState_e         st, stNext;
  logic [SEED_W-1:0] seedCnt, seedNext, seedLast;
  logic [RUN_W-1:0]  runCnt, runNext;
  logic [WIN_W-1:0]  winCnt, winNext;
  logic [ERR_W-1:0]  errWin, errNext;
  logic              modeQ;
  logic              restart;

  assign restart  = !en || (longMode != modeQ);
  assign seedLast = longMode ? SEED_LAST_L : SEED_LAST_S;
  assign locked   = (st == CHK_LOCKED);

  always_comb begin
    stNext   = st;
    seedNext = seedCnt;
    runNext  = runCnt;
    winNext  = winCnt;
    errNext  = errWin;
    strobe   = '0;
    if (restart) begin
      stNext   = CHK_HUNT;
      seedNext = '0;
    end else begin
      unique case (st)
        CHK_HUNT: begin
          strobe.seedShift = 1'b1;
          if (seedCnt == seedLast) begin
            stNext   = CHK_VERIFY;
            seedNext = '0;
            runNext  = '0;
          end else begin
            seedNext = seedCnt + SEED_W'(1);
          end
        end
        CHK_VERIFY: begin
          if (refZero || mismatch) begin
            stNext   = CHK_HUNT;
            seedNext = '0;
          end else begin
            strobe.runShift = 1'b1;
            if (runCnt == RUN_LAST) begin
              stNext  = CHK_LOCKED;
              winNext = '0;
              errNext = '0;
            end else begin
              runNext = runCnt + RUN_W'(1);
            end
          end
        end
        CHK_LOCKED: begin
          strobe.runShift = 1'b1;
          strobe.errHit   = mismatch;
          if (mismatch && (errWin == ERR_LAST)) begin
            stNext   = CHK_HUNT;
            seedNext = '0;
          end else if (winCnt == WIN_LAST) begin
            winNext = '0;
            errNext = '0;
          end else begin
            winNext = winCnt + WIN_W'(1);
            errNext = errWin + ERR_W'(mismatch);
          end
        end
        default: begin
          stNext   = CHK_HUNT;
          seedNext = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= CHK_HUNT;
      seedCnt <= '0;
      runCnt  <= '0;
      winCnt  <= '0;
      errWin  <= '0;
      modeQ   <= 1'b0;
    end else begin
      st      <= stNext;
      seedCnt <= seedNext;
      runCnt  <= runNext;
      winCnt  <= winNext;
      errWin  <= errNext;
      modeQ   <= longMode;
    end
  end

  // R11
  unlock_on_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !locked);

  // R11
  unlock_on_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (longMode != modeQ) |=> (st == CHK_HUNT));

  // R5
  lock_after_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> ($past(runCnt) == RUN_LAST));

  // R8
  err_only_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.errHit |-> locked);

endmodule

// File: rtl/prbs_rx_path.sv
module prbs_rx_path
  import prbs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             longMode,
  input  logic             rxBit,
  input  chkStrobe_t       strobe,
  input  logic             cntClr,
  output logic             mismatch,
  output logic             refZero,
  output logic             errOut,
  output logic [CNT_W-1:0] errCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [REG_W-1:0] refReg;
  logic             predBit;

  assign predBit  = prbsFeedback(refReg, longMode);
  assign mismatch = (rxBit != predBit);
  assign refZero  = prbsAllZero(refReg, longMode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refReg   <= '0;
      errOut   <= 1'b0;
      errCount <= '0;
    end else begin
      if (strobe.seedShift)     refReg <= {refReg[REG_W-2:0], rxBit};
      else if (strobe.runShift) refReg <= {refReg[REG_W-2:0], predBit};
      errOut <= strobe.errHit;
      if (cntClr)                                   errCount <= '0;
      else if (strobe.errHit && errCount != CNT_MAX) errCount <= errCount + CNT_W'(1);
    end
  end

  // R9
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == CNT_MAX && !cntClr) |=> (errCount == CNT_MAX));

  // R10
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntClr |=> (errCount == '0));

  // R9
  cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cntClr |=> (errCount >= $past(errCount)));

  // R6
  err_pulse_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errOut && !$past(cntClr) && ($past(errCount) != CNT_MAX)) |-> (errCount == $past(errCount) + CNT_W'(1)));

endmodule

// File: rtl/prbs_engine.sv
module prbs_engine #(
  parameter int CNT_W     = 16,
  parameter int LOCK_RUN  = 32,
  parameter int WIN_LEN   = 32,
  parameter int LOSS_ERRS = 8
) (
  input  logic             rstN,
  input  logic             prbsEn,
  input  logic             lineMode,
  input  logic             txClk,
  input  logic             txDataIn,
  output logic             txDataOut,
  input  logic             rxClk,
  input  logic             rxDataIn,
  input  logic             errCountClr,
  output logic             errOut,
  output logic             lockOut,
  output logic [CNT_W-1:0] errCount
);

  prbs_pkg::chkStrobe_t chkStrobe;
  logic                 mismatch;
  logic                 refZero;

  prbs_tx_gen uGen (
    .clk      (txClk),
    .rstN     (rstN),
    .en       (prbsEn),
    .longMode (lineMode),
    .dataIn   (txDataIn),
    .dataOut  (txDataOut)
  );

  prbs_rx_ctrl #(
    .LOCK_RUN  (LOCK_RUN),
    .WIN_LEN   (WIN_LEN),
    .LOSS_ERRS (LOSS_ERRS)
  ) uCtrl (
    .clk      (rxClk),
    .rstN     (rstN),
    .en       (prbsEn),
    .longMode (lineMode),
    .mismatch (mismatch),
    .refZero  (refZero),
    .strobe   (chkStrobe),
    .locked   (lockOut)
  );

  prbs_rx_path #(
    .CNT_W (CNT_W)
  ) uPath (
    .clk      (rxClk),
    .rstN     (rstN),
    .longMode (lineMode),
    .rxBit    (rxDataIn),
    .strobe   (chkStrobe),
    .cntClr   (errCountClr),
    .mismatch (mismatch),
    .refZero  (refZero),
    .errOut   (errOut),
    .errCount (errCount)
  );

endmodule

// File: tb/sim_prbs_engine.sv
module sim_prbs_engine;

  logic        clk = 1'b0;
  logic        rstN;
  logic        prbsEn;
  logic        lineMode;
  logic        txDataIn;
  logic        rxDataIn;
  logic        errCountClr;
  logic        txDataOut, errOut, lockOut;
  logic [15:0] errCount;
  logic        txOutB, errOutB, lockOutB;
  logic [3:0]  errCountB;

  always #10 clk = ~clk;

  prbs_engine u0 (
    .rstN(rstN), .prbsEn(prbsEn), .lineMode(lineMode),
    .txClk(clk), .txDataIn(txDataIn), .txDataOut(txDataOut),
    .rxClk(clk), .rxDataIn(rxDataIn), .errCountClr(errCountClr),
    .errOut(errOut), .lockOut(lockOut), .errCount(errCount)
  );

  prbs_engine #(.CNT_W(4)) u1 (
    .rstN(rstN), .prbsEn(prbsEn), .lineMode(lineMode),
    .txClk(clk), .txDataIn(txDataIn), .txDataOut(txOutB),
    .rxClk(clk), .rxDataIn(rxDataIn), .errCountClr(errCountClr),
    .errOut(errOutB), .lockOut(lockOutB), .errCount(errCountB)
  );

  typedef struct {
    logic  expErr;
    logic  expLock;
    int    expCnt;
    int    expSmall;
    string tag;
  } sbItem_t;

  sbItem_t     sbq[$];
  int          vecCount = 0;
  int          failCount = 0;
  int          modelCnt = 0;
  int          modelSmall = 0;
  logic [22:0] hist = '1;
  logic        modelLong = 1'b0;
  bit          done = 0;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
  endtask

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    vecCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic nextRef(output logic b);
    b = modelLong ? (hist[22] ^ hist[17]) : (hist[14] ^ hist[13]);
    hist = {hist[21:0], b};
  endtask

  // driver: applies one receive bit and pushes the expected result
  task automatic sendRaw(input logic b, input logic expE, input logic expL, input logic clr, input string tag);
    sbItem_t it;
    @(negedge clk);
    rxDataIn    = b;
    errCountClr = clr;
    if (clr) begin
      modelCnt = 0; modelSmall = 0;
    end else if (expE) begin
      if (modelCnt < 65535) modelCnt++;
      if (modelSmall < 15) modelSmall++;
    end
    it.expErr = expE; it.expLock = expL; it.expCnt = modelCnt;
    it.expSmall = modelSmall; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic sendRef(input logic flip, input logic expE, input logic expL, input logic clr, input string tag);
    logic b;
    nextRef(b);
    sendRaw(b ^ flip, expE, expL, clr, tag);
  endtask

  task automatic ctrlBit(input logic en, input logic mode, input logic b, input logic expL, input string tag);
    sbItem_t it;
    @(negedge clk);
    prbsEn = en; lineMode = mode; rxDataIn = b; errCountClr = 1'b0;
    it.expErr = 1'b0; it.expLock = expL; it.expCnt = modelCnt;
    it.expSmall = modelSmall; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: compares each scoreboard item after the edge that used its bit
  initial begin
    sbItem_t it;
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        check(errOut === it.expErr, it.tag, "errOut", int'(errOut), int'(it.expErr));
        check(lockOut === it.expLock, it.tag, "lockOut", int'(lockOut), int'(it.expLock));
        check(int'(errCount) == it.expCnt, it.tag, "errCount", int'(errCount), it.expCnt);
        check(int'(errCountB) == it.expSmall, it.tag, "narrow errCount", int'(errCountB), it.expSmall);
      end
    end
  end

  task automatic txPass(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic v;
      @(negedge clk);
      v = 1'($urandom);
      txDataIn = v;
      @(posedge clk);
      #5;
      check(txDataOut === v, tag, "txDataOut passthrough", int'(txDataOut), int'(v));
    end
  endtask

  // collects transmit bits while scrambling txDataIn, then checks recurrences
  task automatic txCollect(input int lenA, input int tapA, input int lenB, input int tapB,
                           input int skip, input string tagOwn, input string tagOther);
    logic bits [0:49];
    int   bad, ones, otherBad;
    for (int i = 0; i < skip; i++) begin
      @(posedge clk);
      #5;
    end
    for (int i = 0; i < 50; i++) begin
      @(posedge clk);
      #5;
      bits[i]  = txDataOut;
      txDataIn = 1'($urandom);
    end
    bad = 0; ones = 0; otherBad = 0;
    for (int i = 0; i < 50; i++) if (bits[i]) ones++;
    for (int i = lenA; i < 50; i++)
      if (bits[i] !== (bits[i-lenA] ^ bits[i-tapA])) bad++;
    for (int i = lenB; i < 50; i++)
      if (bits[i] !== (bits[i-lenB] ^ bits[i-tapB])) otherBad++;
    check(bad == 0, tagOwn, "recurrence violations", bad, 0);
    check(otherBad > 0, tagOther, "other-length recurrence violations (want >0)", otherBad, 1);
    check(ones > 0, "R4", "ones in pattern (want >0)", ones, 1);
  endtask

  initial begin
    #(20 * 100000);
    failCount++;
    $display("FAIL watchdog (all requirements): run still active, actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    rstN = 1'b0; prbsEn = 1'b0; lineMode = 1'b0;
    txDataIn = 1'b1; rxDataIn = 1'b0; errCountClr = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check(txDataOut === 1'b0, "R1", "reset txDataOut", int'(txDataOut), 0);
    check(errOut === 1'b0, "R1", "reset errOut", int'(errOut), 0);
    check(lockOut === 1'b0, "R1", "reset lockOut", int'(lockOut), 0);
    check(errCount == 16'd0, "R1", "reset errCount", int'(errCount), 0);
    @(negedge clk);
    rstN = 1'b1;

    // disabled: passthrough, checker idle
    txPass(8, "R1");
    for (int i = 0; i < 6; i++) sendRaw(1'($urandom), 1'b0, 1'b0, 1'b0, "R1");

    // short pattern: enable, lock, errors, windows
    hist = '1; modelLong = 1'b0;
    begin
      logic b;
      nextRef(b);
      ctrlBit(1'b1, 1'b0, b, 1'b0, "R5");
    end
    fork
      txCollect(15, 14, 23, 18, 0, "R2", "R2");
      begin
        for (int n = 2; n <= 46; n++) sendRef(1'b0, 1'b0, 1'b0, 1'b0, "R5");
        sendRef(1'b0, 1'b0, 1'b1, 1'b0, "R5");
        for (int l = 0; l <= 71; l++) begin
          logic f;
          f = (l == 5) || (l >= 33 && l <= 45 && (l % 2) == 1) || (l >= 64);
          if (l < 32)       sendRef(f, f, 1'b1, 1'b0, "R6");
          else if (l < 64)  sendRef(f, f, 1'b1, 1'b0, "R7");
          else if (l < 70)  sendRef(f, f, 1'b1, 1'b0, "R7");
          else if (l == 70) sendRef(f, f, 1'b1, 1'b0, "R9");
          else              sendRef(f, f, 1'b0, 1'b0, "R7");
        end
        for (int a = 1; a <= 67; a++) begin
          if (a == 20)      sendRef(1'b1, 1'b0, 1'b0, 1'b0, "R8");
          else if (a == 67) sendRef(1'b0, 1'b0, 1'b1, 1'b0, "R7");
          else              sendRef(1'b0, 1'b0, 1'b0, 1'b0, "R8");
        end
        sendRef(1'b1, 1'b1, 1'b1, 1'b1, "R10");
        sendRef(1'b1, 1'b1, 1'b1, 1'b0, "R6");
        sendRef(1'b0, 1'b0, 1'b1, 1'b1, "R10");
      end
    join

    // mode change while locked, then long pattern
    ctrlBit(1'b1, 1'b1, 1'b0, 1'b0, "R11");
    hist = '1; modelLong = 1'b1;
    fork
      txCollect(23, 18, 15, 14, 1, "R3", "R3");
      begin
        for (int n = 1; n <= 54; n++) sendRef(1'b0, 1'b0, 1'b0, 1'b0, "R5");
        sendRef(1'b0, 1'b0, 1'b1, 1'b0, "R5");
        sendRef(1'b1, 1'b1, 1'b1, 1'b0, "R6");
      end
    join

    // disable
    ctrlBit(1'b0, 1'b1, 1'b1, 1'b0, "R11");
    for (int i = 0; i < 4; i++) sendRaw(1'($urandom), 1'b0, 1'b0, 1'b0, "R1");
    txPass(4, "R1");

    // all-zero receive stream
    ctrlBit(1'b1, 1'b0, 1'b0, 1'b0, "R12");
    for (int i = 0; i < 150; i++) sendRaw(1'b0, 1'b0, 1'b0, 1'b0, "R12");
    ctrlBit(1'b0, 1'b0, 1'b0, 1'b0, "R11");

    repeat (4) @(posedge clk);
    #5;
    done = 1;
    report();
    $finish;
  end

endmodule